// File: doc/BRIEF.md
# Serial Byte Repeater with Shortened Stop Bit

This block receives 8N1 asynchronous serial bytes on one line and sends each of them out again on a second line. The far transmitter's clock may be slightly faster than the local one, and neither line has any flow control. The receive path samples the incoming line at sixteen times the bit rate and recovers each byte. A single holding register passes that byte to the transmit path, which frames it again using the local timebase.

An unbroken incoming stream from a slightly fast source would otherwise pile up and overrun. To prevent this, the transmit path ends its stop bit early, at a 1/16-bit granularity, whenever the next byte is already waiting. It never shortens the stop bit below half a bit, so a receiver further down the chain still samples a valid mark at the stop midpoint. Because of this, repeaters can be chained without giving each stage a faster clock than the one before it.

A build-time option selects a different strategy instead. The transmit timebase runs 65/64 of nominal (about 1.6 % fast) and every stop bit is sent at full length. In this mode the extra idle time between bytes absorbs the rate difference.

Top module: `serial_repeater`

## Requirements
- R1: During and directly after reset, `tx_out` is 1 (mark) and both `overrun` and `frame_err` are 0.
- R2: Every byte that is received correctly is sent once on `tx_out`, unchanged, as a 0 start bit, then eight data bits with the least significant bit first, then a 1 stop bit. Each bit lasts 16 ticks, and one tick is `baud_div` clock cycles. The line rests at 1 between frames.
- R3: A start bit is accepted only if the majority of three samples taken around its centre (ticks 7 to 9 after the falling edge is seen) is 0. A low pulse shorter than about a quarter bit produces no byte and no error.
- R4: The receiver takes each data and stop bit as the majority of three samples around the bit centre. It returns to hunting for a start edge at the midpoint of the stop bit, so a frame whose stop bit is only 0.75 bit long is followed by a correctly received next frame.
- R5: With the default option, an outgoing stop bit lasts at least `STOP_MIN_TICKS` ticks (default 8). It ends early, on any later tick, when a byte is waiting. A back-to-back input stream about 3 % faster than nominal is therefore forwarded byte for byte without overrun.
- R6: With `BOOST_TX` = 1, the transmit tick runs at 65/64 of the nominal rate and every stop bit is a full 16 ticks. A back-to-back stream at the nominal rate is forwarded without overrun.
- R7: If a byte completes while the previously held byte has not yet begun transmission, the held byte is replaced and `overrun` goes to 1. It stays at 1 until reset.
- R8: If the stop bit's majority sample is 0, `frame_err` goes to 1 and stays at 1 until reset. That byte is not forwarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_in | input | 1 | Incoming serial line, asynchronous to clk |
| baud_div | input | DIV_W | Clock cycles per 1/16-bit tick (0 counts as 1) |
| tx_out | output | 1 | Outgoing serial line |
| overrun | output | 1 | Sticky flag: a held byte was overwritten |
| frame_err | output | 1 | Sticky flag: a stop bit was sampled low |

## Verification
A correct byte is handed over at the midpoint of its incoming stop bit. The incoming edge reaches the receiver through two synchroniser flops and is then aligned to the next receive tick. The forwarded start bit then begins at the first transmit tick on which the transmitter is free, so it appears on `tx_out` within one tick of that midpoint. The bench reads the output with its own decoder. The decoder is triggered by each falling edge of `tx_out` and samples 28 clocks later, then every 64 clocks, off the clock edge. These points stay inside each bit for both the shortened stop bit and the 65/64 boost rate. `overrun` and `frame_err` are registered one cycle after the event that causes them, so the bench reads them only after a margin of at least one full frame.

// File: rtl/srep_pkg.sv
package srep_pkg;
   localparam int OVS     = 16;          // ticks per bit
   localparam int HALF    = OVS / 2;
   localparam int DATA_W  = 8;
   localparam int FRAC_SH = 6;           // tick generator fractional shift
   localparam int STEP_NOM = 1 << FRAC_SH;
   localparam int STEP_BOOST = STEP_NOM + 1;  // 65/64 rate

   typedef enum logic [1:0] {
      TX_IDLE,
      TX_START,
      TX_DATA,
      TX_STOP
   } tx_state_e;
endpackage

// File: rtl/srep_tick_gen.sv
// Fractional tick generator: one tick per (div * 2^FRAC_SH / STEP) cycles.
module srep_tick_gen
   import srep_pkg::*;
#(
   parameter int DIV_W = 16,
   parameter int STEP  = STEP_NOM
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   localparam int ACC_W = DIV_W + FRAC_SH + 2;

   logic [ACC_W-1:0] acc;
   logic [ACC_W-1:0] lim;
   logic [ACC_W-1:0] nxt;

   always_comb begin
      lim = (div == '0) ? ACC_W'(STEP_NOM) : (ACC_W'(div) << FRAC_SH);
      nxt = acc + ACC_W'(STEP);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc  <= '0;
         tick <= 1'b0;
      end else if (nxt >= lim) begin
         acc  <= nxt - lim;
         tick <= 1'b1;
      end else begin
         acc  <= nxt;
         tick <= 1'b0;
      end
   end
endmodule

// File: rtl/srep_rx.sv
// Oversampling receiver: majority of three samples per bit, rehunts at stop midpoint.
module srep_rx
   import srep_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_in,
   input  logic              tick,
   output logic [DATA_W-1:0] data,
   output logic              valid,
   output logic              ferr
);
   localparam int PH_LAST = OVS * (DATA_W + 1) + HALF + 1;
   localparam int PH_W    = $clog2(PH_LAST + 1);
   localparam int POS_W   = $clog2(OVS);

   logic              sync1, rx_s;
   logic              busy;
   logic [PH_W-1:0]   ph;
   logic [POS_W-1:0]  pos;
   logic [PH_W-1:0]   idx;
   logic [1:0]        vote;
   logic              maj;
   logic [DATA_W-1:0] sh;

   always_comb begin
      pos = POS_W'(ph % PH_W'(OVS));
      idx = ph / PH_W'(OVS);
      maj = (vote[0] & vote[1]) | (vote[0] & rx_s) | (vote[1] & rx_s);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync1 <= 1'b1;
         rx_s  <= 1'b1;
      end else begin
         sync1 <= rx_in;
         rx_s  <= sync1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         ph    <= '0;
         vote  <= 2'b11;
         sh    <= '0;
         data  <= '0;
         valid <= 1'b0;
         ferr  <= 1'b0;
      end else begin
         valid <= 1'b0;
         ferr  <= 1'b0;
         if (tick) begin
            if (!busy) begin
               if (!rx_s) begin
                  busy <= 1'b1;
                  ph   <= '0;
               end
            end else begin
               ph <= ph + 1'b1;
               if (pos == POS_W'(HALF - 1) || pos == POS_W'(HALF))
                  vote <= {vote[0], rx_s};
               if (pos == POS_W'(HALF + 1)) begin
                  if (idx == '0) begin
                     if (maj) busy <= 1'b0;       // false start
                  end else if (idx <= PH_W'(DATA_W)) begin
                     sh <= {maj, sh[DATA_W-1:1]};
                  end else begin
                     busy <= 1'b0;                // hunt again from stop midpoint
                     if (maj) begin
                        valid <= 1'b1;
                        data  <= sh;
                     end else begin
                        ferr <= 1'b1;
                     end
                  end
               end
            end
         end
      end
   end
endmodule

// File: rtl/srep_tx.sv
// Transmitter whose stop bit may end early once STOP_MIN ticks have elapsed.
module srep_tx
   import srep_pkg::*;
#(
   parameter int STOP_MIN = HALF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              pend,
   input  logic [DATA_W-1:0] pend_data,
   output logic              take,
   output logic              line
);
   localparam int POS_W = $clog2(OVS);
   localparam int BI_W  = $clog2(DATA_W);

   tx_state_e         state;
   logic [POS_W-1:0]  tcnt;
   logic [BI_W-1:0]   bidx;
   logic [DATA_W-1:0] sh;
   logic              last;
   logic              can_start;

   always_comb begin
      last      = (tcnt == POS_W'(OVS - 1));
      can_start = (state == TX_IDLE) ||
                  (state == TX_STOP && tcnt >= POS_W'(STOP_MIN - 1));
      take      = tick && pend && can_start;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= TX_IDLE;
         tcnt  <= '0;
         bidx  <= '0;
         sh    <= '0;
         line  <= 1'b1;
      end else if (tick) begin
         if (take) begin
            sh    <= pend_data;
            line  <= 1'b0;
            state <= TX_START;
            tcnt  <= '0;
         end else begin
            case (state)
               TX_IDLE: line <= 1'b1;
               TX_START: begin
                  if (last) begin
                     line  <= sh[0];
                     sh    <= sh >> 1;
                     bidx  <= '0;
                     tcnt  <= '0;
                     state <= TX_DATA;
                  end else tcnt <= tcnt + 1'b1;
               end
               TX_DATA: begin
                  if (last) begin
                     tcnt <= '0;
                     if (bidx == BI_W'(DATA_W - 1)) begin
                        line  <= 1'b1;
                        state <= TX_STOP;
                     end else begin
                        line <= sh[0];
                        sh   <= sh >> 1;
                        bidx <= bidx + 1'b1;
                     end
                  end else tcnt <= tcnt + 1'b1;
               end
               TX_STOP: begin
                  if (last) begin
                     tcnt  <= '0;
                     state <= TX_IDLE;
                  end else tcnt <= tcnt + 1'b1;
               end
               default: state <= TX_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/serial_repeater.sv
module serial_repeater
   import srep_pkg::*;
#(
   parameter int DIV_W          = 16,
   parameter int STOP_MIN_TICKS = HALF,
   parameter bit BOOST_TX       = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_in,
   input  logic [DIV_W-1:0] baud_div,
   output logic             tx_out,
   output logic             overrun,
   output logic             frame_err
);
   // Boost variant keeps full stop bits; shortening variant uses STOP_MIN_TICKS.
   localparam int EFF_STOP = BOOST_TX ? OVS : STOP_MIN_TICKS;

   if (DIV_W < 2 || DIV_W > 24) begin : g_bad_div
      $error("serial_repeater: DIV_W must be 2..24");
   end
   if (STOP_MIN_TICKS < HALF || STOP_MIN_TICKS > OVS) begin : g_bad_stop
      $error("serial_repeater: STOP_MIN_TICKS must be HALF..OVS");
   end

   logic              rx_tick, tx_tick;
   logic [DATA_W-1:0] rx_data;
   logic              rx_valid, rx_ferr;
   logic [DATA_W-1:0] hold_data;
   logic              hold_full;
   logic              tx_take;

   srep_tick_gen #(.DIV_W(DIV_W), .STEP(STEP_NOM)) u_rx_tick (
      .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(rx_tick)
   );

   if (BOOST_TX) begin : g_boost
      srep_tick_gen #(.DIV_W(DIV_W), .STEP(STEP_BOOST)) u_tx_tick (
         .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tx_tick)
      );
   end else begin : g_nominal
      srep_tick_gen #(.DIV_W(DIV_W), .STEP(STEP_NOM)) u_tx_tick (
         .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tx_tick)
      );
   end

   srep_rx u_rx (
      .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .tick(rx_tick),
      .data(rx_data), .valid(rx_valid), .ferr(rx_ferr)
   );

   srep_tx #(.STOP_MIN(EFF_STOP)) u_tx (
      .clk(clk), .rst_n(rst_n), .tick(tx_tick),
      .pend(hold_full), .pend_data(hold_data),
      .take(tx_take), .line(tx_out)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_data <= '0;
         hold_full <= 1'b0;
         overrun   <= 1'b0;
         frame_err <= 1'b0;
      end else begin
         if (rx_valid) begin
            hold_data <= rx_data;
            hold_full <= 1'b1;
            if (hold_full && !tx_take) overrun <= 1'b1;
         end else if (tx_take) begin
            hold_full <= 1'b0;
         end
         if (rx_ferr) frame_err <= 1'b1;
      end
   end
endmodule

// File: rtl/srep_chk.sv
module srep_chk #(
   parameter int STOP_MIN = 8
) (
   input logic clk,
   input logic rst_n,
   input logic tx_out,
   input logic tx_tick,
   input logic tx_take,
   input logic hold_full,
   input logic rx_valid,
   input logic rx_ferr,
   input logic overrun,
   input logic frame_err
);
   logic [4:0] hi_ticks;

   always_ff @(posedge clk) begin
      if (!rst_n || !tx_out) hi_ticks <= '0;
      else if (tx_tick && hi_ticks != 5'd31) hi_ticks <= hi_ticks + 1'b1;
   end

   p_idle_high_r1: assert property (@(posedge clk) $rose(rst_n) |-> tx_out);
   p_take_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_take |-> hold_full);
   p_tx_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_out) |-> $past(tx_tick));
   p_stop_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_out) |-> hi_ticks >= 5'(STOP_MIN));
   p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);
   p_overrun_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun) |-> $past(rx_valid && hold_full && !tx_take));
   p_ferr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |=> frame_err);
   p_ferr_no_fwd_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ferr |-> !rx_valid);
endmodule

bind serial_repeater srep_chk #(.STOP_MIN(EFF_STOP)) u_chk (
   .clk(clk), .rst_n(rst_n), .tx_out(tx_out), .tx_tick(tx_tick),
   .tx_take(tx_take), .hold_full(hold_full), .rx_valid(rx_valid),
   .rx_ferr(rx_ferr), .overrun(overrun), .frame_err(frame_err)
);

// File: tb/serial_repeater_tb_top.sv
module serial_repeater_tb_top;
   localparam int CLK_P = 10;
   localparam int DIV   = 4;
   localparam int BITC  = 16 * DIV;   // clocks per nominal bit
   localparam int FASTC = 62;         // about 3 % fast

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] line = 3'b111;
   logic       tx0, tx1, tx2, ov0, ov1, ov2, fe0, fe1, fe2;
   int         n_run = 0, n_fail = 0;
   logic [7:0] exp_q [2][256];
   int         wr [2] = '{0, 0};
   int         rd [2] = '{0, 0};

   always #(CLK_P/2) clk = ~clk;

   serial_repeater dut_i (
      .clk(clk), .rst_n(rst_n), .rx_in(line[0]), .baud_div(16'(DIV)),
      .tx_out(tx0), .overrun(ov0), .frame_err(fe0));
   serial_repeater #(.BOOST_TX(1'b1)) dut_boost_i (
      .clk(clk), .rst_n(rst_n), .rx_in(line[1]), .baud_div(16'(DIV)),
      .tx_out(tx1), .overrun(ov1), .frame_err(fe1));
   serial_repeater #(.STOP_MIN_TICKS(16)) dut_full_i (
      .clk(clk), .rst_n(rst_n), .rx_in(line[2]), .baud_div(16'(DIV)),
      .tx_out(tx2), .overrun(ov2), .frame_err(fe2));

   task automatic chk(string req, int act, int expv);
      n_run++;
      if (act != expv) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic waitn(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send(int w, logic [7:0] b, int bitc, int stopc, logic stopv);
      line[w] = 1'b0;
      waitn(bitc);
      for (int i = 0; i < 8; i++) begin
         line[w] = b[i];
         waitn(bitc);
      end
      line[w] = stopv;
      waitn(stopc);
      line[w] = 1'b1;
   endtask

   function automatic logic get_tx(int w);
      return (w == 0) ? tx0 : tx1;
   endfunction

   // Bench decoder of an output line, nominal bit period (R2)
   task automatic mon(int w);
      logic [7:0] got;
      forever begin
         do @(negedge clk); while (get_tx(w) != 1'b0);
         waitn(27);
         chk("R2 start bit", int'(get_tx(w)), 0);
         for (int i = 0; i < 8; i++) begin
            waitn(BITC);
            got[i] = get_tx(w);
         end
         waitn(BITC);
         chk("R2 stop bit", int'(get_tx(w)), 1);
         if (rd[w] < wr[w]) chk("R2 byte", int'(got), int'(exp_q[w][rd[w]]));
         else chk("R2 unexpected byte", int'(got), -1);
         rd[w]++;
      end
   endtask

   task automatic push(int w, logic [7:0] b);
      exp_q[w][wr[w]] = b;
      wr[w]++;
   endtask

   task automatic summary;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      logic [7:0] b;
      logic [7:0] dir [6] = '{8'h00, 8'hFF, 8'h55, 8'hA5, 8'h80, 8'h01};
      void'($urandom(32'd20240611));
      waitn(10);
      // R1: reset state
      chk("R1 tx0", int'(tx0), 1); chk("R1 tx1", int'(tx1), 1); chk("R1 tx2", int'(tx2), 1);
      chk("R1 ov", int'(ov0 | ov1 | ov2), 0); chk("R1 fe", int'(fe0 | fe1 | fe2), 0);
      rst_n = 1'b1;
      waitn(4);
      chk("R1 tx after reset", int'(tx0 & tx1 & tx2), 1);
      fork mon(0); mon(1); join_none

      // R2/R6: directed then random nominal back-to-back stream
      for (int i = 0; i < 36; i++) begin
         b = (i < 6) ? dir[i] : 8'($urandom());
         push(0, b); push(1, b);
         fork send(0, b, BITC, BITC, 1'b1); send(1, b, BITC, BITC, 1'b1); join
      end
      waitn(2000);
      chk("R6 boost no overrun", int'(ov1), 0);
      chk("R2 nominal no overrun", int'(ov0), 0);
      chk("R2 all bytes out", rd[0], wr[0]);
      chk("R6 all bytes out", rd[1], wr[1]);

      // R5 / R7: 3 % fast back-to-back stream
      for (int i = 0; i < 60; i++) begin
         b = 8'($urandom());
         push(0, b);
         fork send(0, b, FASTC, FASTC, 1'b1); send(2, b, FASTC, FASTC, 1'b1); join
         if (i == 5) chk("R7 no early overrun", int'(ov2), 0);
      end
      waitn(2000);
      chk("R5 fast stream no overrun", int'(ov0), 0);
      chk("R5 fast stream all bytes", rd[0], wr[0]);
      chk("R7 full-stop variant overruns", int'(ov2), 1);
      waitn(500);
      chk("R7 overrun sticky", int'(ov2), 1);

      // R4: short 0.75-bit stop bits
      for (int i = 0; i < 20; i++) begin
         b = 8'($urandom());
         push(0, b);
         send(0, b, BITC, 48, 1'b1);
      end
      waitn(2000);
      chk("R4 short stop bytes", rd[0], wr[0]);
      chk("R4 no frame error", int'(fe0), 0);

      // R3: short glitch is not a start bit
      line[0] = 1'b0; waitn(16); line[0] = 1'b1;
      waitn(1500);
      chk("R3 glitch no byte", rd[0], wr[0]);
      chk("R3 glitch no frame error", int'(fe0), 0);

      // R8: low stop bit
      send(0, 8'h3C, BITC, BITC, 1'b0);
      waitn(1500);
      chk("R8 frame error set", int'(fe0), 1);
      chk("R8 byte not forwarded", rd[0], wr[0]);
      push(0, 8'hC3);
      send(0, 8'hC3, BITC, BITC, 1'b1);
      waitn(1500);
      chk("R8 next byte forwarded", rd[0], wr[0]);
      chk("R8 frame error sticky", int'(fe0), 1);
      summary();
   end
endmodule